// File: doc/BRIEF.md
# Short-Address DMA Transfer Channel

This block is one DMA channel that copies data, one byte or one 16-bit word per request, between a 24-bit memory address and a 16-bit address. The 16-bit address is sign-extended into the 24-bit space. As a result it reaches either the lowest 32 KB or the highest 32 KB of that space, which is where peripheral registers usually live. Software programs the channel through a small register write port. Once enabled, the channel waits for requests from either an internal interrupt pulse or an external request pin.

In dual-address operation, every request makes two accesses on a generic bus master port: a read from the source, then a write of the captured data to the destination. In single-address operation, the channel makes one access at the 24-bit address and raises an acknowledge towards the device. The device then supplies or takes the data itself, and the 16-bit address is not used.

Three modes set how the 24-bit address and the transfer count change:
- Sequential mode walks the address and stops when the count reaches zero.
- Idle mode keeps the address fixed.
- Repeat mode reloads both the address and the count from saved copies and keeps running.

Top module: `dma_short_chan`

## Requirements
- R1: After a synchronous active-low reset, `bus_valid`, `bus_ack` and `end_irq` are low and the channel is disabled, so requests cause no bus activity.
- R2: The 16-bit address is sign-extended to 24 bits. Bit 15 set gives an address of the form 0xFFxxxx; bit 15 clear gives 0x00xxxx.
- R3: In dual mode each transfer is one read at the source followed by one write of the read data to the destination. Control bit 5 clear makes the 24-bit address the source and the 16-bit address the destination; bit 5 set swaps them.
- R4: Once `bus_valid` is high, it stays high with `bus_addr` and `bus_write` unchanged until `bus_ready` is seen high.
- R5: In single mode (control bit 4 set) each transfer is exactly one access at the 24-bit address, with `bus_ack` high during it. The access is a read when bit 5 is clear and a write when bit 5 is set.
- R6: Control bit 1 selects word size: `bus_word` follows it. In sequential and repeat modes the 24-bit address advances by 2 for words and by 1 for bytes after each transfer, wrapping modulo 2^24.
- R7: In idle mode (control bits 3:2 = 01) the 24-bit address stays the same for every transfer.
- R8: The count register decrements on each completed transfer. The transfer that brings it to zero produces a one-cycle `end_irq` pulse. In sequential mode (bits 3:2 = 00) and idle mode, that transfer also clears the enable, so later requests do nothing.
- R9: In repeat mode (bits 3:2 = 10), the transfer that brings the count to zero pulses `end_irq`, reloads the count and the 24-bit address from the values last written, and leaves the channel enabled.
- R10: Each request moves exactly one unit. A request that arrives during a transfer is held and served after that transfer. Only one request is held: further requests arriving while one is waiting are merged into it.
- R11: Control bit 6 clear selects `irq_pulse` as the request source (each high cycle is one request). Bit 6 set selects a rising edge on `ext_req`. The unselected source is ignored.
- R12: Requests that arrive while the enable (control bit 0) is clear are dropped and are not served when the channel is enabled later.
- R13: Register writes use `cfg_sel`: 0 = 24-bit address (also its reload copy), 1 = 16-bit address, 2 = count (also its reload copy), 3 = control.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select |
| cfg_wdata | input | 24 | Register write data |
| irq_pulse | input | 1 | Internal interrupt request, one cycle per request |
| ext_req | input | 1 | External request pin, rising edge requests |
| bus_valid | output | 1 | Bus access request |
| bus_addr | output | 24 | Bus address |
| bus_write | output | 1 | 1 = write, 0 = read |
| bus_word | output | 1 | 1 = word access, 0 = byte access |
| bus_wdata | output | 16 | Write data (dual mode) |
| bus_rdata | input | 16 | Read data |
| bus_ready | input | 1 | Access completes this cycle |
| bus_ack | output | 1 | Device acknowledge in single mode |
| end_irq | output | 1 | One-cycle pulse when the count reaches zero |

## Verification
The following are checked by assertions on every cycle:
- The bus handshake holds while `bus_ready` is low.
- The acknowledge is raised only during an access.
- A dual transfer ends with a write.
- A request is taken only when the bus is quiet.
- The count steps down by one on each transfer.
- Idle mode keeps the address, and repeat mode reloads its values.
- A held request implies the channel was enabled.

Only the bench scenarios can show the following:
- The actual address sequences.
- The sign extension.
- The copied data values.
- Where the channel stops after the count runs out.
- Merging of surplus requests.
- Selection between the two request sources.
- Dropping of requests made while the channel is disabled.

// File: rtl/dmach_pkg.sv
// Shared types for the short-address DMA channel.
// Assumes the control word layout: bit0 enable, bit1 word size, bits3:2 mode,
// bit4 single-address, bit5 narrow side is source, bit6 external request source.
package dmach_pkg;

    typedef enum logic [1:0] {
        OPM_SEQ  = 2'b00,
        OPM_IDLE = 2'b01,
        OPM_RPT  = 2'b10,
        OPM_RSV  = 2'b11
    } opmode_e;

    typedef enum logic [1:0] {
        REG_WIDE   = 2'd0,
        REG_NARROW = 2'd1,
        REG_COUNT  = 2'd2,
        REG_CTRL   = 2'd3
    } regsel_e;

    typedef struct packed {
        logic    src_ext;
        logic    narrow_src;
        logic    single;
        opmode_e mode;
        logic    word;
        logic    en;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_READ,
        ST_WRITE,
        ST_SINGLE
    } bstate_e;

endpackage

// File: rtl/dmach_req.sv
// Request capture: selects the internal pulse or a rising edge of the external
// pin, and holds at most one request until the sequencer takes it.
// Assumes ext_req is already synchronous to clk.
module dmach_req (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic src_ext,
    input  logic irq_pulse,
    input  logic ext_req,
    input  logic take,
    output logic pend
);

    logic ext_q;
    logic ext_rise;
    logic req;

    // Edge detection and request source selection.
    assign ext_rise = ext_req & ~ext_q;
    assign req      = src_ext ? ext_rise : irq_pulse;

    // Remember the previous level of the external pin.
    always_ff @(posedge clk) begin
        if (!rst_n) ext_q <= 1'b0;
        else        ext_q <= ext_req;
    end

    // Single pending slot; dropped while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n)   pend <= 1'b0;
        else if (!en) pend <= 1'b0;
        else          pend <= (pend & ~take) | req;
    end

    AST_PEND_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        pend |-> $past(en)); // R12

endmodule

// File: rtl/dmach_regs.sv
// Channel registers: 24-bit address with reload copy, 16-bit address, count
// with reload copy, control. Updates address and count at each completed
// transfer according to the operating mode. Register writes win over updates.
module dmach_regs
    import dmach_pkg::*;
#(
    parameter int WIDE_AW   = 24,
    parameter int NARROW_AW = 16,
    parameter int CNT_W     = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [1:0]           cfg_sel,
    input  logic [WIDE_AW-1:0]   cfg_wdata,
    input  logic                 done,
    output ctrl_t                ctrl,
    output logic [WIDE_AW-1:0]   wide,
    output logic [NARROW_AW-1:0] narrow,
    output logic [CNT_W-1:0]     cnt,
    output logic                 end_irq
);

    localparam logic [WIDE_AW-1:0] STEP_B = WIDE_AW'(1);
    localparam logic [WIDE_AW-1:0] STEP_W = WIDE_AW'(2);

    logic [WIDE_AW-1:0] wide_save;
    logic [CNT_W-1:0]   cnt_save;
    logic [WIDE_AW-1:0] wide_next;
    logic               last;

    // Next 24-bit address after one transfer.
    always_comb begin
        if (ctrl.mode == OPM_IDLE) wide_next = wide;
        else                       wide_next = wide + (ctrl.word ? STEP_W : STEP_B);
    end

    assign last = (cnt == CNT_W'(1));

    // Register writes and per-transfer updates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl      <= '0;
            wide      <= '0;
            wide_save <= '0;
            narrow    <= '0;
            cnt       <= '0;
            cnt_save  <= '0;
            end_irq   <= 1'b0;
        end else begin
            end_irq <= 1'b0;
            if (cfg_we) begin
                case (regsel_e'(cfg_sel))
                    REG_WIDE: begin
                        wide      <= cfg_wdata;
                        wide_save <= cfg_wdata;
                    end
                    REG_NARROW: narrow <= cfg_wdata[NARROW_AW-1:0];
                    REG_COUNT: begin
                        cnt      <= cfg_wdata[CNT_W-1:0];
                        cnt_save <= cfg_wdata[CNT_W-1:0];
                    end
                    default: ctrl <= ctrl_t'(cfg_wdata[CTRL_W-1:0]);
                endcase
            end else if (done) begin
                if (last) begin
                    end_irq <= 1'b1;
                    if (ctrl.mode == OPM_RPT) begin
                        wide <= wide_save;
                        cnt  <= cnt_save;
                    end else begin
                        wide    <= wide_next;
                        cnt     <= '0;
                        ctrl.en <= 1'b0;
                    end
                end else begin
                    wide <= wide_next;
                    cnt  <= cnt - CNT_W'(1);
                end
            end
        end
    end

    AST_IDLE_HOLDS_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        done && !cfg_we && ctrl.mode == OPM_IDLE && !last |=> $stable(wide)); // R7

    AST_COUNT_DECR: assert property (@(posedge clk) disable iff (!rst_n)
        done && !cfg_we && !last |=> cnt == CNT_W'($past(cnt) - CNT_W'(1))); // R8

    AST_STOP_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        done && !cfg_we && last && ctrl.mode != OPM_RPT |=> !ctrl.en && end_irq); // R8

    AST_REPEAT_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        done && !cfg_we && last && ctrl.mode == OPM_RPT
        |=> ctrl.en && cnt == cnt_save && wide == wide_save && end_irq); // R9

endmodule

// File: rtl/dmach_seq.sv
// Bus sequencer: takes one held request, then runs a read and a write (dual
// address) or a single acknowledged access, holding each access until ready.
// Assumes the control fields stay unchanged while a transfer runs.
module dmach_seq
    import dmach_pkg::*;
#(
    parameter int WIDE_AW = 24,
    parameter int DATA_W  = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  ctrl_t              ctrl,
    input  logic [WIDE_AW-1:0] wide,
    input  logic [WIDE_AW-1:0] narrow_ext,
    input  logic               pend,
    output logic               take,
    output logic               done,
    output logic               bus_valid,
    output logic [WIDE_AW-1:0] bus_addr,
    output logic               bus_write,
    output logic               bus_word,
    output logic [DATA_W-1:0]  bus_wdata,
    input  logic [DATA_W-1:0]  bus_rdata,
    input  logic               bus_ready,
    output logic               bus_ack
);

    bstate_e            st;
    logic [DATA_W-1:0]  data_q;
    logic [WIDE_AW-1:0] src_addr;
    logic [WIDE_AW-1:0] dst_addr;

    // Start and finish strobes for one transfer unit.
    assign take = (st == ST_IDLE) && ctrl.en && pend;
    assign done = ((st == ST_WRITE) || (st == ST_SINGLE)) && bus_ready;

    // Map wide and narrow addresses onto source and destination.
    assign src_addr = ctrl.narrow_src ? narrow_ext : wide;
    assign dst_addr = ctrl.narrow_src ? wide : narrow_ext;

    // Bus outputs decoded from the sequencer state.
    always_comb begin
        bus_valid = 1'b0;
        bus_addr  = '0;
        bus_write = 1'b0;
        bus_wdata = '0;
        bus_ack   = 1'b0;
        bus_word  = ctrl.word;
        case (st)
            ST_READ: begin
                bus_valid = 1'b1;
                bus_addr  = src_addr;
            end
            ST_WRITE: begin
                bus_valid = 1'b1;
                bus_addr  = dst_addr;
                bus_write = 1'b1;
                bus_wdata = data_q;
            end
            ST_SINGLE: begin
                bus_valid = 1'b1;
                bus_addr  = wide;
                bus_write = ctrl.narrow_src;
                bus_ack   = 1'b1;
            end
            default: ;
        endcase
    end

    // State progression and read data capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= ST_IDLE;
            data_q <= '0;
        end else begin
            case (st)
                ST_IDLE:   if (take) st <= ctrl.single ? ST_SINGLE : ST_READ;
                ST_READ:   if (bus_ready) begin
                               data_q <= bus_rdata;
                               st     <= ST_WRITE;
                           end
                ST_WRITE:  if (bus_ready) st <= ST_IDLE;
                default:   if (bus_ready) st <= ST_IDLE;
            endcase
        end
    end

    AST_HOLD_UNTIL_READY: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid && !bus_ready |=> bus_valid && $stable(bus_addr) && $stable(bus_write)); // R4

    AST_ACK_IN_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ack |-> bus_valid); // R5

    AST_DUAL_ENDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_valid) && !$past(bus_ack) |-> $past(bus_write)); // R3

    AST_TAKE_WHEN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> !bus_valid); // R10

endmodule

// File: rtl/dma_short_chan.sv
// Top of the short-address DMA channel: register file, request capture and
// bus sequencer. The narrow address is sign-extended into the wide space.
// Assumes a single bus master port with a valid/ready handshake.
module dma_short_chan
    import dmach_pkg::*;
#(
    parameter int WIDE_AW   = 24,
    parameter int NARROW_AW = 16,
    parameter int CNT_W     = 16,
    parameter int DATA_W    = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [1:0]         cfg_sel,
    input  logic [WIDE_AW-1:0] cfg_wdata,
    input  logic               irq_pulse,
    input  logic               ext_req,
    output logic               bus_valid,
    output logic [WIDE_AW-1:0] bus_addr,
    output logic               bus_write,
    output logic               bus_word,
    output logic [DATA_W-1:0]  bus_wdata,
    input  logic [DATA_W-1:0]  bus_rdata,
    input  logic               bus_ready,
    output logic               bus_ack,
    output logic               end_irq
);

    localparam int EXT_W = WIDE_AW - NARROW_AW;

    ctrl_t                ctrl;
    logic [WIDE_AW-1:0]   wide;
    logic [NARROW_AW-1:0] narrow;
    logic [CNT_W-1:0]     cnt;
    logic [WIDE_AW-1:0]   narrow_ext;
    logic                 pend;
    logic                 take;
    logic                 done;

    // Sign-extend the narrow address into the wide space.
    assign narrow_ext = {{EXT_W{narrow[NARROW_AW-1]}}, narrow};

    dmach_regs #(
        .WIDE_AW  (WIDE_AW),
        .NARROW_AW(NARROW_AW),
        .CNT_W    (CNT_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_sel  (cfg_sel),
        .cfg_wdata(cfg_wdata),
        .done     (done),
        .ctrl     (ctrl),
        .wide     (wide),
        .narrow   (narrow),
        .cnt      (cnt),
        .end_irq  (end_irq)
    );

    dmach_req u_req (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (ctrl.en),
        .src_ext  (ctrl.src_ext),
        .irq_pulse(irq_pulse),
        .ext_req  (ext_req),
        .take     (take),
        .pend     (pend)
    );

    dmach_seq #(
        .WIDE_AW(WIDE_AW),
        .DATA_W (DATA_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl      (ctrl),
        .wide      (wide),
        .narrow_ext(narrow_ext),
        .pend      (pend),
        .take      (take),
        .done      (done),
        .bus_valid (bus_valid),
        .bus_addr  (bus_addr),
        .bus_write (bus_write),
        .bus_word  (bus_word),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .bus_ready (bus_ready),
        .bus_ack   (bus_ack)
    );

    AST_END_IS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        end_irq |=> !end_irq || $past(done)); // R8

endmodule

// File: tb/tb_dma_short_chan.sv
module tb_dma_short_chan;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 6;
    localparam logic [15:0] RD_KEY = 16'h5A3C;

    typedef struct packed {
        logic [1:0]  mode;
        logic        word;
        logic        single;
        logic        dir;
        logic [23:0] wide;
        logic [15:0] narrow;
        logic [15:0] cnt;
        logic [3:0]  nreq;
    } vec_t;

    localparam vec_t VECS [NV] = '{
        '{2'b00, 1'b0, 1'b0, 1'b0, 24'h001000, 16'h0040, 16'd3, 4'd4},
        '{2'b00, 1'b1, 1'b0, 1'b1, 24'h200000, 16'h9000, 16'd2, 4'd2},
        '{2'b01, 1'b0, 1'b1, 1'b0, 24'h345678, 16'h1234, 16'd3, 4'd3},
        '{2'b10, 1'b1, 1'b1, 1'b1, 24'h0000F0, 16'h0000, 16'd2, 4'd5},
        '{2'b10, 1'b0, 1'b0, 1'b0, 24'hFFFFFE, 16'h7FFF, 16'd3, 4'd4},
        '{2'b01, 1'b1, 1'b0, 1'b1, 24'h00ABCD, 16'h8000, 16'd1, 4'd2}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = '0;
    logic [23:0] cfg_wdata = '0;
    logic        irq_pulse = 1'b0;
    logic        ext_req = 1'b0;
    logic        ready_en = 1'b1;
    logic        bus_valid, bus_write, bus_word, bus_ack, end_irq, bus_ready;
    logic [23:0] bus_addr;
    logic [15:0] bus_wdata, bus_rdata;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    logic [23:0] log_addr [128];
    logic        log_we   [128];
    logic        log_word [128];
    logic        log_ack  [128];
    logic [15:0] log_data [128];
    int log_n = 0;
    int end_n = 0;

    assign bus_ready = bus_valid & ready_en;
    assign bus_rdata = bus_addr[15:0] ^ RD_KEY;

    dma_short_chan dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .irq_pulse(irq_pulse), .ext_req(ext_req),
        .bus_valid(bus_valid), .bus_addr(bus_addr), .bus_write(bus_write),
        .bus_word(bus_word), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_ready(bus_ready), .bus_ack(bus_ack), .end_irq(end_irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Bus and interrupt monitor.
    always @(posedge clk) begin
        if (rst_n && bus_valid && bus_ready && log_n < 128) begin
            log_addr[log_n] <= bus_addr;
            log_we[log_n]   <= bus_write;
            log_word[log_n] <= bus_word;
            log_ack[log_n]  <= bus_ack;
            log_data[log_n] <= bus_wdata;
            log_n <= log_n + 1;
        end
        if (rst_n && end_irq) end_n <= end_n + 1;
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cfg_wr(input logic [1:0] sel, input logic [23:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic pulse_irq();
        @(negedge clk);
        irq_pulse = 1'b1;
        @(negedge clk);
        irq_pulse = 1'b0;
    endtask

    function automatic logic [23:0] sext(input logic [15:0] n);
        return {{8{n[15]}}, n};
    endfunction

    function automatic logic [23:0] ctrlw(input logic src, input logic dir, input logic single,
                                          input logic [1:0] mode, input logic word, input logic en);
        return {17'h0, src, dir, single, mode, word, en};
    endfunction

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        vec_t t;
        int base_n, base_e, nx, ne, per, idx, j;
        logic [23:0] wa, na, exp_addr, stall_addr;
        logic exp_we;

        idle(4);
        // R1: reset state
        check(bus_valid == 0 && bus_ack == 0 && end_irq == 0, "R1 outputs in reset",
              {bus_valid, bus_ack, end_irq}, 0);
        @(negedge clk) rst_n = 1'b1;
        idle(2);
        check(bus_valid == 0 && bus_ack == 0 && end_irq == 0, "R1 outputs after reset",
              {bus_valid, bus_ack, end_irq}, 0);
        base_n = log_n;
        pulse_irq();
        idle(8);
        check(log_n == base_n, "R1 disabled after reset", log_n - base_n, 0);

        // Vector table walk: R2 R3 R5 R6 R7 R8 R9 R13
        for (int v = 0; v < NV; v++) begin
            t = VECS[v];
            base_n = log_n;
            base_e = end_n;
            cfg_wr(2'd0, t.wide);
            cfg_wr(2'd1, {8'h0, t.narrow});
            cfg_wr(2'd2, {8'h0, t.cnt});
            cfg_wr(2'd3, ctrlw(1'b0, t.dir, t.single, t.mode, t.word, 1'b1));
            for (int k = 0; k < int'(t.nreq); k++) begin
                pulse_irq();
                idle(8);
            end
            per = t.single ? 1 : 2;
            if (t.mode == 2'b10) begin
                nx = t.nreq;
                ne = t.nreq / t.cnt;
            end else begin
                nx = (t.nreq < t.cnt) ? t.nreq : t.cnt;
                ne = (t.nreq >= t.cnt) ? 1 : 0;
            end
            check(log_n - base_n == nx * per, "R8 R9 transfer count", log_n - base_n, nx * per);
            check(end_n - base_e == ne, "R8 R9 end pulses", end_n - base_e, ne);
            na = sext(t.narrow);
            for (int k = 0; k < nx; k++) begin
                idx = (t.mode == 2'b10) ? (k % int'(t.cnt)) : k;
                wa = (t.mode == 2'b01) ? t.wide : 24'(t.wide + idx * (t.word ? 2 : 1));
                j = base_n + k * per;
                if (t.single) begin
                    check(log_addr[j] == wa && log_ack[j] == 1 && log_we[j] == t.dir && log_word[j] == t.word,
                          "R5 R6 R7 single access", {log_ack[j], log_we[j], log_word[j], log_addr[j]},
                          {1'b1, t.dir, t.word, wa});
                end else begin
                    exp_addr = t.dir ? na : wa;
                    check(log_addr[j] == exp_addr && log_we[j] == 0 && log_ack[j] == 0 && log_word[j] == t.word,
                          "R2 R3 R6 R7 read access", {log_we[j], log_word[j], log_addr[j]},
                          {1'b0, t.word, exp_addr});
                    exp_addr = t.dir ? wa : na;
                    check(log_addr[j+1] == exp_addr && log_we[j+1] == 1 && log_ack[j+1] == 0
                          && log_data[j+1] == (log_addr[j][15:0] ^ RD_KEY),
                          "R2 R3 R6 write access", {log_we[j+1], log_data[j+1], log_addr[j+1]},
                          {1'b1, log_addr[j][15:0] ^ RD_KEY, exp_addr});
                end
            end
        end

        // R10: back-to-back requests, one held, extras merged
        cfg_wr(2'd0, 24'h000400);
        cfg_wr(2'd1, 16'h0010);
        cfg_wr(2'd2, 24'd20);
        cfg_wr(2'd3, ctrlw(1'b0, 1'b0, 1'b1, 2'b00, 1'b0, 1'b1));
        base_n = log_n;
        @(negedge clk) irq_pulse = 1'b1;
        idle(3);
        irq_pulse = 1'b0;
        idle(10);
        check(log_n - base_n == 2, "R10 held request served once", log_n - base_n, 2);
        check(log_addr[base_n+1] == 24'h000401, "R10 second unit address", log_addr[base_n+1], 24'h000401);

        // R4: stalled bus keeps the access steady
        ready_en = 1'b0;
        base_n = log_n;
        pulse_irq();
        idle(2);
        stall_addr = bus_addr;
        exp_we = bus_write;
        idle(3);
        check(bus_valid == 1 && bus_addr == stall_addr && bus_write == exp_we && stall_addr == 24'h000402,
              "R4 access held during stall", {bus_valid, bus_addr}, {1'b1, 24'h000402});
        ready_en = 1'b1;
        idle(5);
        check(log_n - base_n == 1, "R4 one access after stall", log_n - base_n, 1);

        // R11: external source; internal pulse ignored, rising edge counts once
        cfg_wr(2'd3, ctrlw(1'b1, 1'b0, 1'b1, 2'b00, 1'b0, 1'b1));
        base_n = log_n;
        pulse_irq();
        idle(8);
        check(log_n == base_n, "R11 internal pulse ignored", log_n - base_n, 0);
        @(negedge clk) ext_req = 1'b1;
        idle(10);
        check(log_n - base_n == 1, "R11 level held gives one transfer", log_n - base_n, 1);
        ext_req = 1'b0;
        idle(2);
        ext_req = 1'b1;
        idle(8);
        ext_req = 1'b0;
        check(log_n - base_n == 2, "R11 second rising edge", log_n - base_n, 2);

        // R12: requests while disabled are dropped
        cfg_wr(2'd3, ctrlw(1'b0, 1'b0, 1'b1, 2'b00, 1'b0, 1'b0));
        base_n = log_n;
        pulse_irq();
        idle(2);
        cfg_wr(2'd3, ctrlw(1'b0, 1'b0, 1'b1, 2'b00, 1'b0, 1'b1));
        idle(8);
        check(log_n == base_n, "R12 dropped request", log_n - base_n, 0);
        check(end_irq == 0 && bus_valid == 0, "R12 quiet outputs", {end_irq, bus_valid}, 0);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule